// File: doc/BRIEF.md
# Width-Aware FIFO with Level Thresholds

This block is the data buffer that sits between a bus-side agent and a serial shifter. It stores up to 256 bytes. Software picks an entry width of 8, 16 or 32 bits, and each push or pop then moves one entry of that width. The fill level is reported in entries of the current width, not in bytes. Data is accepted and returned through valid/ready handshakes. A buffer that has not been started neither takes nor gives data.

Several compare outputs report how full the buffer is. A programmable threshold is compared against the level in entries. Its sense depends on a parameter: a transmit-side instance flags "drained down to the threshold", and a receive-side instance flags "filled up to the threshold". Three 6-bit marks (stop, low and high) are compared against the level counted in 4-byte units. Full and empty are exported as events for the interrupt logic. A one-cycle error strobe reports a push into a full buffer or a pop from an empty one.

Top module: `wfifo`

## Requirements
- R1: After reset the buffer is stopped and empty. The status word reads 0x200, `rd_data` is zero and `err` is low.
- R2: A write to `op_code` acts as follows. Bit 0 set flushes both pointers and the level. Bit 1 set starts the buffer. Bit 1 clear stops it. Both bits together flush and start in one write. No push or pop is accepted in the cycle of an operation write.
- R3: While stopped, `wr_ready` and `rd_valid` are low, pushes are ignored and `rd_data` is zero. Pop attempts do not move the read pointer, so the stored data is still there, in order, after a restart.
- R4: Entries come out in the order they went in.
- R5: The status word carries the level in entries of the current width in bits [7:0], full in bit 8 and empty in bit 9, with all other bits zero. `full_evt` and `empty_evt` mirror bits 8 and 9.
- R6: The capacity is 256 bytes, which is 256, 128 or 64 entries depending on width. When full, `wr_ready` is low.
- R7: In 8-bit mode a completely full buffer reports level bits [7:0] as 0 (the count modulo 256), with the full bit set.
- R8: While running, a push attempt when full or a pop attempt when empty is ignored. It raises `err` for exactly the following cycle. Accepted transfers never raise `err`.
- R9: The threshold is `ctrl_word[9:2]`, counted in entries. With `IS_TX`=1, `thr_hit` is high when the level is at or below the threshold. With `IS_TX`=0, it is high when the level is at or above the threshold.
- R10: The marks sit in `mark_word`: stop in [5:0], low in [15:10] and high in [25:20]. They are compared against the stored byte count divided by 4. `lo_hit` means units <= low. `hi_hit` means units >= high. `stop_hit` means units >= stop when `IS_TX`=1, and units <= stop when `IS_TX`=0.
- R11: An entry takes the low 8, 16 or 32 bits of `wr_data`, stored little-endian. `rd_data` returns the entry zero-extended.
- R12: The width field `ctrl_word[1:0]` selects 0 for 8-bit, 1 for 16-bit, and 2 or 3 for 32-bit entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_wr | input | 1 | Operation write strobe |
| op_code | input | 2 | Bit 0 flush, bit 1 start/run |
| ctrl_word | input | 10 | [1:0] entry width, [9:2] threshold |
| mark_word | input | 26 | Stop [5:0], low [15:10], high [25:20] marks |
| wr_valid | input | 1 | Push request |
| wr_data | input | 32 | Push data |
| wr_ready | output | 1 | Push accepted this cycle when high with wr_valid |
| rd_ready | input | 1 | Pop request |
| rd_valid | output | 1 | Head entry available |
| rd_data | output | 32 | Head entry, zero-extended; zero when not valid |
| stat_word | output | 32 | Level, full and empty status |
| thr_hit | output | 1 | Threshold reached |
| full_evt | output | 1 | Buffer full |
| empty_evt | output | 1 | Buffer empty |
| stop_hit | output | 1 | Stop mark reached |
| lo_hit | output | 1 | Low mark reached |
| hi_hit | output | 1 | High mark reached |
| err | output | 1 | One-cycle overflow/underflow strobe |

## Verification
The bench builds two copies at the default 256-byte depth, one with `IS_TX`=1 and one with `IS_TX`=0, and drives both with the same stimulus. This lets a single sequence check both threshold and stop-mark polarities against each other. The default depth allows a complete 256-entry fill in 8-bit mode, which is the only case where the 8-bit level field wraps to zero while full. The bench also fills the buffer to 64 entries through the reserved width code.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;

  typedef enum logic [1:0] {
    EW_BYTE = 2'd0,
    EW_HALF = 2'd1,
    EW_WORD = 2'd2,
    EW_WIDE = 2'd3
  } ewidth_e;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  function automatic logic [2:0] entry_bytes(input logic [1:0] code);
    case (ewidth_e'(code))
      EW_BYTE: entry_bytes = 3'd1;
      EW_HALF: entry_bytes = 3'd2;
      default: entry_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] entry_shift(input logic [1:0] code);
    case (ewidth_e'(code))
      EW_BYTE: entry_shift = 2'd0;
      EW_HALF: entry_shift = 2'd1;
      default: entry_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/wfifo_store.sv
module wfifo_store #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      wr_ptr,
  input  logic [LANES-1:0]   lane_en,
  input  logic [8*LANES-1:0] wr_data,
  input  logic [AW-1:0]      rd_ptr,
  output logic [8*LANES-1:0] rd_raw
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < LANES; k++) begin
        if (lane_en[k]) begin
          mem[AW'(wr_ptr + AW'(k))] <= wr_data[8*k +: 8];
        end
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd_lane
    assign rd_raw[8*g +: 8] = mem[AW'(rd_ptr + AW'(g))];
  end

endmodule

// File: rtl/wfifo_ctl.sv
module wfifo_ctl #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_wr,
  input  logic          op_flush,
  input  logic          op_start,
  input  logic          wr_valid,
  input  logic          rd_ready,
  input  logic [2:0]    ebytes,
  output logic          run,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic          push,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty,
  output logic          err
);

  localparam logic [CW:0] CAP = (CW+1)'(DEPTH);

  logic          pop, bad, upd;
  logic          run_d;
  logic [AW-1:0] wp_d, rp_d;
  logic [CW-1:0] cnt_d, add_b, sub_b;
  logic [CW:0]   cnt_after;

  // occupancy decode
  always_comb begin
    cnt_after = {1'b0, cnt} + (CW+1)'(ebytes);
    full      = cnt_after > CAP;
    empty     = cnt < CW'(ebytes);
    wr_ready  = run & ~full & ~op_wr;
    rd_valid  = run & ~empty & ~op_wr;
    push      = wr_valid & wr_ready;
    pop       = rd_ready & rd_valid;
    bad       = run & ~op_wr & ((wr_valid & full) | (rd_ready & empty));
    upd       = op_wr | push | pop;
  end

  // next state
  always_comb begin
    add_b = push ? CW'(ebytes) : '0;
    sub_b = pop  ? CW'(ebytes) : '0;
    run_d = op_wr ? op_start : run;
    if (op_wr && op_flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      wp_d  = push ? AW'(wr_ptr + AW'(ebytes)) : wr_ptr;
      rp_d  = pop  ? AW'(rd_ptr + AW'(ebytes)) : rd_ptr;
      cnt_d = cnt + add_b - sub_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (upd) begin
      run    <= run_d;
      wr_ptr <= wp_d;
      rd_ptr <= rp_d;
      cnt    <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0;
    end else begin
      err <= bad;
    end
  end

endmodule

// File: rtl/wfifo_lvl.sv
module wfifo_lvl #(
  parameter int CW     = 9,
  parameter int THR_W  = 8,
  parameter int MARK_W = 6,
  parameter bit IS_TX  = 1'b1
) (
  input  logic [CW-1:0]     cnt,
  input  logic [1:0]        eshift,
  input  logic [THR_W-1:0]  thr,
  input  logic [MARK_W-1:0] stop_mk,
  input  logic [MARK_W-1:0] lo_mk,
  input  logic [MARK_W-1:0] hi_mk,
  input  logic              full,
  input  logic              empty,
  output logic [31:0]       stat_word,
  output logic              thr_hit,
  output logic              stop_hit,
  output logic              lo_hit,
  output logic              hi_hit
);

  localparam int LVL_FIELD_W = 8;

  logic [CW-1:0] level;
  logic [CW-1:0] units;
  logic [CW-1:0] thr_x, stop_x, lo_x, hi_x;

  always_comb begin
    level  = cnt >> eshift;
    units  = cnt >> 2;
    thr_x  = CW'(thr);
    stop_x = CW'(stop_mk);
    lo_x   = CW'(lo_mk);
    hi_x   = CW'(hi_mk);
    lo_hit = units <= lo_x;
    hi_hit = units >= hi_x;
    stat_word = {22'd0, empty, full, LVL_FIELD_W'(level)};
  end

  if (IS_TX) begin : g_tx
    assign thr_hit  = level <= thr_x;
    assign stop_hit = units >= stop_x;
  end else begin : g_rx
    assign thr_hit  = level >= thr_x;
    assign stop_hit = units <= stop_x;
  end

endmodule

// File: rtl/wfifo.sv
module wfifo
  import wfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter bit IS_TX = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_wr,
  input  logic [1:0]  op_code,
  input  logic [9:0]  ctrl_word,
  input  logic [25:0] mark_word,
  input  logic        wr_valid,
  input  logic [31:0] wr_data,
  output logic        wr_ready,
  input  logic        rd_ready,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic [31:0] stat_word,
  output logic        thr_hit,
  output logic        full_evt,
  output logic        empty_evt,
  output logic        stop_hit,
  output logic        lo_hit,
  output logic        hi_hit,
  output logic        err
);

  localparam int AW       = $clog2(DEPTH);
  localparam int CW       = AW + 1;
  localparam int THR_LSB  = 2;
  localparam int THR_W    = 8;
  localparam int MARK_W   = 6;
  localparam int STOP_LSB = 0;
  localparam int LO_LSB   = 10;
  localparam int HI_LSB   = 20;

  logic [1:0]        wcode;
  logic [2:0]        ebytes;
  logic [1:0]        eshift;
  logic              run, push, full, empty;
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt;
  logic [LANES-1:0]  lane_en;
  logic [DATA_W-1:0] rd_raw, rd_shaped;

  wire unused_mark_gaps = ^{mark_word[9:6], mark_word[19:16]};

  assign wcode  = ctrl_word[1:0];
  assign ebytes = entry_bytes(wcode);
  assign eshift = entry_shift(wcode);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_en
    assign lane_en[g] = 3'(g) < ebytes;
  end

  wfifo_ctl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_wr    (op_wr),
    .op_flush (op_code[0]),
    .op_start (op_code[1]),
    .wr_valid (wr_valid),
    .rd_ready (rd_ready),
    .ebytes   (ebytes),
    .run      (run),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .push     (push),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .cnt      (cnt),
    .full     (full),
    .empty    (empty),
    .err      (err)
  );

  wfifo_store #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES)) u_store (
    .clk     (clk),
    .we      (push),
    .wr_ptr  (wr_ptr),
    .lane_en (lane_en),
    .wr_data (wr_data),
    .rd_ptr  (rd_ptr),
    .rd_raw  (rd_raw)
  );

  // shape the head entry to the selected width
  always_comb begin
    case (ewidth_e'(wcode))
      EW_BYTE: rd_shaped = {24'd0, rd_raw[7:0]};
      EW_HALF: rd_shaped = {16'd0, rd_raw[15:0]};
      default: rd_shaped = rd_raw;
    endcase
    rd_data = rd_valid ? rd_shaped : '0;
  end

  wfifo_lvl #(.CW(CW), .THR_W(THR_W), .MARK_W(MARK_W), .IS_TX(IS_TX)) u_lvl (
    .cnt       (cnt),
    .eshift    (eshift),
    .thr       (ctrl_word[THR_LSB +: THR_W]),
    .stop_mk   (mark_word[STOP_LSB +: MARK_W]),
    .lo_mk     (mark_word[LO_LSB +: MARK_W]),
    .hi_mk     (mark_word[HI_LSB +: MARK_W]),
    .full      (full),
    .empty     (empty),
    .stat_word (stat_word),
    .thr_hit   (thr_hit),
    .stop_hit  (stop_hit),
    .lo_hit    (lo_hit),
    .hi_hit    (hi_hit)
  );

  assign full_evt  = full;
  assign empty_evt = empty;

endmodule

// File: rtl/wfifo_chk.sv
module wfifo_chk #(
  parameter int DEPTH = 256,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_wr,
  input logic          op_flush,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          rd_ready,
  input logic          rd_valid,
  input logic [31:0]   rd_data,
  input logic          full,
  input logic          empty,
  input logic          err,
  input logic          run,
  input logic [CW-1:0] cnt
);

  a_r6_full_blocks_push: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_ready);

  a_r3_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (rd_data == 32'd0 && !wr_ready && !rd_valid));

  a_r2_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && op_flush) |=> empty);

  a_r8_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(run && (wr_valid || rd_ready)));

  a_r5_level_holds_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_wr && !(wr_valid && wr_ready) && !(rd_ready && rd_valid)) |=> $stable(cnt));

  a_r5_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, empty}));

endmodule

bind wfifo wfifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_wr    (op_wr),
  .op_flush (op_code[0]),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .rd_ready (rd_ready),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .full     (full),
  .empty    (empty),
  .err      (err),
  .run      (run),
  .cnt      (cnt)
);

// File: tb/wfifo_bench.sv
`timescale 1ns/1ps
module wfifo_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_wr;
  logic [1:0]  op_code;
  logic [9:0]  ctrl_word;
  logic [25:0] mark_word;
  logic        wr_valid, rd_ready;
  logic [31:0] wr_data;

  logic        wr_ready, rd_valid, thr_hit, full_evt, empty_evt, stop_hit, lo_hit, hi_hit, err;
  logic [31:0] rd_data, stat_word;
  logic        x_wr_ready, x_rd_valid, x_thr_hit, x_full_evt, x_empty_evt, x_stop_hit, x_lo_hit, x_hi_hit, x_err;
  logic [31:0] x_rd_data, x_stat_word;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  wfifo #(.DEPTH(256), .IS_TX(1'b1)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_code(op_code), .ctrl_word(ctrl_word),
    .mark_word(mark_word), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .stat_word(stat_word),
    .thr_hit(thr_hit), .full_evt(full_evt), .empty_evt(empty_evt), .stop_hit(stop_hit),
    .lo_hit(lo_hit), .hi_hit(hi_hit), .err(err));

  wfifo #(.DEPTH(256), .IS_TX(1'b0)) u_wfifo_rx (
    .clk(clk), .rst_n(rst_n), .op_wr(op_wr), .op_code(op_code), .ctrl_word(ctrl_word),
    .mark_word(mark_word), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(x_wr_ready),
    .rd_ready(rd_ready), .rd_valid(x_rd_valid), .rd_data(x_rd_data), .stat_word(x_stat_word),
    .thr_hit(x_thr_hit), .full_evt(x_full_evt), .empty_evt(x_empty_evt), .stop_hit(x_stop_hit),
    .lo_hit(x_lo_hit), .hi_hit(x_hi_hit), .err(x_err));

  // vector: {pop, data (push value or expected pop value), level after}
  localparam int NV = 8;
  localparam logic [40:0] VEC [NV] = '{
    {1'b0, 32'hA1B2C3D4, 8'd1},
    {1'b0, 32'h00000001, 8'd2},
    {1'b1, 32'hA1B2C3D4, 8'd1},
    {1'b0, 32'hFFFF0000, 8'd2},
    {1'b0, 32'h5A5A5A5A, 8'd3},
    {1'b1, 32'h00000001, 8'd2},
    {1'b1, 32'hFFFF0000, 8'd1},
    {1'b1, 32'h5A5A5A5A, 8'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    #1;
  endtask

  task automatic pop_try();
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    #1;
  endtask

  task automatic pop_chk(input string tag, input logic [31:0] exp);
    chk(tag, rd_data, exp);
    pop_try();
  endtask

  task automatic opw(input logic [1:0] c);
    op_wr   = 1'b1;
    op_code = c;
    @(negedge clk);
    op_wr = 1'b0;
    #1;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; op_wr = 1'b0; op_code = 2'b00; ctrl_word = '0; mark_word = '0;
    wr_valid = 1'b0; rd_ready = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    chk("R1 status", stat_word, 32'h200);
    chk("R1 rd_data", rd_data, 32'd0);
    chk("R1 err", {31'd0, err}, 32'd0);
    chk("R3 ready while stopped", {30'd0, wr_ready, rd_valid}, 32'd0);
    push(32'hDEAD);
    chk("R3 push ignored stopped", stat_word, 32'h200);

    // word mode, threshold 3, start
    ctrl_word = {8'd3, 2'd2};
    opw(2'b10);
    chk("R2 started ready", {31'd0, wr_ready}, 32'd1);

    // table walk: R4 order, R5 level
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) pop_chk($sformatf("R4 vec%0d data", i), VEC[i][39:8]);
      else            push(VEC[i][39:8]);
      chk($sformatf("R5 vec%0d level", i), stat_word, {22'd0, VEC[i][7:0] == 8'd0, 1'b0, VEC[i][7:0]});
    end

    // R9 threshold polarity
    push(32'h1); push(32'h2);
    chk("R9 lvl2 tx/rx", {30'd0, thr_hit, x_thr_hit}, 32'b10);
    push(32'h3);
    chk("R9 lvl3 tx/rx", {30'd0, thr_hit, x_thr_hit}, 32'b11);
    push(32'h4);
    chk("R9 lvl4 tx/rx", {30'd0, thr_hit, x_thr_hit}, 32'b01);
    opw(2'b11);
    chk("R2 flush+start", stat_word, 32'h200);
    chk("R2 still running", {31'd0, wr_ready}, 32'd1);

    // 16-bit mode, marks stop=5 low=1 high=3
    ctrl_word = {8'd3, 2'd1};
    mark_word = (26'd3 << 20) | (26'd1 << 10) | 26'd5;
    push(32'h1111ABCD); push(32'h2222BEEF); push(32'h3333CAFE);
    chk("R5 half level", stat_word, 32'h003);
    chk("R10 6 bytes lo/hi", {30'd0, lo_hit, hi_hit}, 32'b10);
    push(32'h4444F00D);
    chk("R10 8 bytes lo/hi/stop tx/rx", {28'd0, lo_hit, hi_hit, stop_hit, x_stop_hit}, 32'b0001);
    push(32'h55550001); push(32'h66660002);
    chk("R10 12 bytes hi", {31'd0, hi_hit}, 32'd1);
    chk("R12 half level 6", stat_word, 32'h006);
    pop_chk("R11 half zero-extend", 32'h0000ABCD);

    // R3 stop keeps data and pointer
    opw(2'b00);
    chk("R3 rd_data stopped", rd_data, 32'd0);
    push(32'h7777AAAA);
    pop_try();
    chk("R3 level kept", stat_word, 32'h005);
    chk("R8 no err when stopped", {31'd0, err}, 32'd0);
    opw(2'b10);
    pop_chk("R3 resume order", 32'h0000BEEF);

    // R8 underflow
    opw(2'b11);
    pop_try();
    chk("R8 pop empty err", {31'd0, err}, 32'd1);
    @(negedge clk); #1;
    chk("R8 err one cycle", {31'd0, err}, 32'd0);
    push(32'h9);
    chk("R8 accepted no err", {31'd0, err}, 32'd0);

    // byte mode full fill
    ctrl_word = {8'd3, 2'd0};
    opw(2'b11);
    for (int k = 0; k < 256; k++) push({24'hABCDEF, 8'(k)});
    chk("R7 byte full level wraps", stat_word, 32'h100);
    chk("R6 full evt / ready", {30'd0, full_evt, wr_ready}, 32'b10);
    push(32'h55);
    chk("R8 push full err", {31'd0, err}, 32'd1);
    chk("R8 push full ignored", stat_word, 32'h100);
    pop_chk("R11 byte zero-extend", 32'h00000000);
    chk("R6 one free", stat_word, 32'h0FF);
    pop_chk("R4 byte order", 32'h00000001);

    // R12 width code 3 acts as 32-bit
    ctrl_word = {8'd3, 2'd3};
    opw(2'b11);
    for (int k = 0; k < 64; k++) push(32'hC0DE0000 | k);
    chk("R12 wide full at 64", stat_word, 32'h140);
    chk("R6 wide ready low", {31'd0, wr_ready}, 32'd0);
    pop_chk("R12 wide data", 32'hC0DE0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule